// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address-Mark Wakeup

This block receives asynchronous serial frames (start bit, data bits sent LSB first, an optional parity bit, stop bit) from a line that is sampled on a 16x baud tick. Each bit is resolved by a 2-of-3 majority vote taken around the middle of the bit. Completed frames are placed in a holding register, which is offered downstream through a valid/ready pair. The serial line cannot be stalled, so back-pressure works like this. The holding register and its flags are released only by a handshake (`rd_valid_o && rd_ready_i` on a clock edge). While `rd_valid_o` is high, `rd_data_o` and the flags stay fixed. A frame that completes while the register is still occupied is dropped, and the overrun flag is raised instead.

On a bus shared by several receivers, the top data bit of every frame tells an address frame (1) from a data frame (0). When address-mark mode is on, software can put the receiver to sleep for the rest of a message that is not meant for it. While asleep, frames are neither delivered nor flagged. A frame whose top bit is 1 wakes the receiver as soon as that bit is resolved, which is before the stop bit is sampled, so that address frame is delivered normally. The frame size and the parity configuration must be held steady while a frame is being received.

Top module: `uart_wake_rx`

## Requirements
- R1: In idle, a low line seen on a tick starts a frame. If the majority vote at the middle of the start bit reads high, the frame is abandoned and nothing is delivered.
- R2: With `cfg_nine_i`=0 a frame has 8 data bits, and the address mark is `rd_data_o[7]`. With `cfg_nine_i`=1 it has 9 data bits, and the mark is `rd_data_o[8]`. The bits are received LSB first and right-justified, and unused upper bits read 0.
- R3: With `cfg_par_en_i`=1, one parity bit follows the data bits. `rd_pf_o` is set when the data bits plus the parity bit have an odd number of ones (`cfg_par_odd_i`=0) or an even number (`cfg_par_odd_i`=1).
- R4: `rd_fe_o` is set when the stop bit resolves low. The data bits are still delivered.
- R5: `rd_nf_o` is set when the three samples of any bit in the frame disagree. The delivered bit value is the majority of the three samples.
- R6: A delivered frame raises `rd_valid_o`. A cycle with `rd_valid_o` and `rd_ready_i` both high clears `rd_valid_o` and all four flags. While the register is not consumed, `rd_data_o` does not change.
- R7: A frame that completes while `rd_valid_o` is high and is not being consumed sets `rd_or_o` and leaves `rd_data_o` unchanged.
- R8: `rwu_set_i` sets `rwu_o` only while `cfg_wake_i`=1. With `cfg_wake_i`=0 the strobe is ignored and `rwu_o` stays 0.
- R9: While `rwu_o` is 1, a frame whose top data bit is 0 changes neither `rd_valid_o` nor any flag, even if it has a framing error.
- R10: While `rwu_o` is 1, a frame whose top data bit is 1 clears `rwu_o` before its stop bit is sampled, and that frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle enable at 16x the baud rate |
| cfg_nine_i | input | 1 | 1: 9 data bits per frame, 0: 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit present after the data bits |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_wake_i | input | 1 | Address-mark wakeup mode enable |
| rwu_set_i | input | 1 | Strobe that puts the receiver to sleep |
| rwu_o | output | 1 | Receiver asleep |
| rd_valid_o | output | 1 | Holding register full |
| rd_ready_i | input | 1 | Consumer takes the holding register |
| rd_data_o | output | 9 | Received data bits, right-justified |
| rd_nf_o | output | 1 | Noise seen in the held frame |
| rd_fe_o | output | 1 | Framing error in the held frame |
| rd_pf_o | output | 1 | Parity error in the held frame |
| rd_or_o | output | 1 | A later frame was lost to overrun |

## Verification
The hardest case to reach is the wake-up moment. The sleep flag must drop inside the address frame, after its top data bit is resolved but before its stop bit is sampled. The bench probes `rwu_o` at the instant it starts driving the stop bit, and then checks that the same frame appears in the holding register. Before that, a sleeping receiver is given a data frame that carries a framing error, to show that neither the valid signal nor any flag moves. Noise is produced by a one-tick glitch placed near a bit centre, so that exactly one of the three votes disagrees.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef struct packed {
    logic nf;
    logic fe;
    logic pf;
  } rx_err_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/uart_bit_sampler.sv
module uart_bit_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic stb_o,
  output logic val_o,
  output logic noisy_o
);
  localparam int PW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [PW-1:0] PH_A = PW'(MID - 1);
  localparam logic [PW-1:0] PH_B = PW'(MID);
  localparam logic [PW-1:0] PH_C = PW'(MID + 1);

  logic [PW-1:0] phase;
  logic          s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      s_a   <= 1'b1;
      s_b   <= 1'b1;
    end else if (!run_i) begin
      phase <= '0;
    end else if (tick_i) begin
      phase <= phase + 1'b1;
      if (phase == PH_A) s_a <= rx_i;
      if (phase == PH_B) s_b <= rx_i;
    end
  end

  assign stb_o   = run_i && tick_i && (phase == PH_C);
  assign val_o   = (s_a & s_b) | (s_a & rx_i) | (s_b & rx_i);
  assign noisy_o = !((s_a == s_b) && (s_b == rx_i));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_wake_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o,
  output logic              msb_stb_o,
  output logic              msb_val_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_WIDE = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_NARW = CW'(DATA_W - 2);

  fr_state_t         st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic              pbit, noise;
  logic              stb, val, nz;
  logic [CW-1:0]     last;

  uart_bit_sampler #(.OSR(OSR)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st != FR_IDLE),
    .tick_i (tick_i),
    .rx_i   (rx_i),
    .stb_o  (stb),
    .val_o  (val),
    .noisy_o(nz)
  );

  assign last = cfg_nine_i ? LAST_WIDE : LAST_NARW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= FR_IDLE;
      cnt   <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      noise <= 1'b0;
    end else begin
      case (st)
        FR_IDLE: if (tick_i && !rx_i) begin
          st    <= FR_START;
          cnt   <= '0;
          sh    <= '0;
          noise <= 1'b0;
        end
        FR_START: if (stb) begin
          st    <= val ? FR_IDLE : FR_DATA;
          noise <= noise | nz;
        end
        FR_DATA: if (stb) begin
          sh[cnt] <= val;
          noise   <= noise | nz;
          if (cnt == last) begin
            cnt <= '0;
            st  <= cfg_par_en_i ? FR_PAR : FR_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        FR_PAR: if (stb) begin
          pbit  <= val;
          noise <= noise | nz;
          st    <= FR_STOP;
        end
        FR_STOP: if (stb) st <= FR_IDLE;
        default: st <= FR_IDLE;
      endcase
    end
  end

  assign done_o    = (st == FR_STOP) && stb;
  assign data_o    = sh;
  assign err_o.nf  = noise | nz;
  assign err_o.fe  = !val;
  assign err_o.pf  = cfg_par_en_i && ((^sh) ^ pbit ^ cfg_par_odd_i);
  assign msb_stb_o = (st == FR_DATA) && stb && (cnt == last);
  assign msb_val_o = val;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_wake_i,
  input  logic              rwu_set_i,
  output logic              rwu_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_nf_o,
  output logic              rd_fe_o,
  output logic              rd_pf_o,
  output logic              rd_or_o
);
  logic              rx_s;
  logic              done, msb_stb, msb_val;
  logic [DATA_W-1:0] fr_data;
  rx_err_t           fr_err;
  logic              deliver, consume;

  uart_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (rx_i),
    .q_o  (rx_s)
  );

  uart_frame_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .rx_i         (rx_s),
    .cfg_nine_i   (cfg_nine_i),
    .cfg_par_en_i (cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i),
    .done_o       (done),
    .data_o       (fr_data),
    .err_o        (fr_err),
    .msb_stb_o    (msb_stb),
    .msb_val_o    (msb_val)
  );

  // Sleep flag: address mark clears it ahead of the stop bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rwu_o <= 1'b0;
    else if (!cfg_wake_i)        rwu_o <= 1'b0;
    else if (msb_stb && msb_val) rwu_o <= 1'b0;
    else if (rwu_set_i)          rwu_o <= 1'b1;
  end

  assign deliver = done && !rwu_o;
  assign consume = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_nf_o    <= 1'b0;
      rd_fe_o    <= 1'b0;
      rd_pf_o    <= 1'b0;
      rd_or_o    <= 1'b0;
    end else begin
      if (consume) begin
        rd_valid_o <= 1'b0;
        rd_nf_o    <= 1'b0;
        rd_fe_o    <= 1'b0;
        rd_pf_o    <= 1'b0;
        rd_or_o    <= 1'b0;
      end
      if (deliver) begin
        if (rd_valid_o && !consume) begin
          rd_or_o <= 1'b1;
        end else begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= fr_data;
          rd_nf_o    <= fr_err.nf;
          rd_fe_o    <= fr_err.fe;
          rd_pf_o    <= fr_err.pf;
          rd_or_o    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wake_i,
  input logic              rwu_set_i,
  input logic              rwu_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_nf_o,
  input logic              rd_fe_o,
  input logic              rd_pf_o,
  input logic              rd_or_o
);
  // R6
  valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid_o) |-> $past(rd_ready_i));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_data_o));

  // R7
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_nf_o || rd_fe_o || rd_pf_o || rd_or_o) |-> rd_valid_o);

  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwu_o) |-> $past(rwu_set_i && cfg_wake_i));

  // R9
  asleep_no_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rwu_o && $past(rwu_o)) |-> !$rose(rd_valid_o));
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       nine = 1'b0, par_en = 1'b0, par_odd = 1'b0, wake = 1'b0;
  logic       rwu_set = 1'b0, rd_ready = 1'b0;
  logic       rwu, rd_valid, nf, fe, pf, ovr;
  logic [8:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_wake_rx i_uart_wake_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
    .cfg_nine_i(nine), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
    .cfg_wake_i(wake), .rwu_set_i(rwu_set), .rwu_o(rwu),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .rd_nf_o(nf), .rd_fe_o(fe), .rd_pf_o(pf), .rd_or_o(ovr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_idx: data bit that gets a one-tick inverted pulse near its centre
  task automatic send(input logic [8:0] d, input int n, input bit use_par,
                      input bit pval, input bit stop_v, input int glitch_idx,
                      input bit probe_rwu);
    rx = 1'b0; hold(BIT_CLKS);
    for (int i = 0; i < n; i++) begin
      if (i == glitch_idx) begin
        rx = d[i]; hold(16); rx = ~d[i]; hold(2); rx = d[i]; hold(BIT_CLKS-18);
      end else begin
        rx = d[i]; hold(BIT_CLKS);
      end
    end
    if (use_par) begin rx = pval; hold(BIT_CLKS); end
    if (probe_rwu) check("R10 rwu cleared before stop", rwu, 0);
    rx = stop_v; hold(BIT_CLKS);
    rx = 1'b1; hold(8);
  endtask

  task automatic consume();
    rd_ready = 1'b1; hold(1); rd_ready = 1'b0; hold(1);
  endtask

  task automatic t_reset();
    check("R6 reset valid", rd_valid, 0);
    check("R6 reset flags", {nf, fe, pf, ovr}, 0);
    check("R8 reset rwu", rwu, 0);
  endtask

  task automatic t_basic();
    nine = 0; par_en = 0;
    send(9'h0A5, 8, 0, 0, 1, -1, 0);
    check("R2 8-bit data", rd_data, 9'h0A5);
    check("R6 valid after frame", rd_valid, 1);
    check("R2 clean flags", {nf, fe, pf, ovr}, 0);
    consume();
    check("R6 valid cleared by handshake", rd_valid, 0);
  endtask

  task automatic t_nine();
    nine = 1;
    send(9'h1C3, 9, 0, 0, 1, -1, 0);
    check("R2 9-bit data", rd_data, 9'h1C3);
    consume();
    nine = 0;
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send(9'h05B, 8, 1, ^8'h5B, 1, -1, 0);
    check("R3 even parity ok", pf, 0);
    consume();
    send(9'h05B, 8, 1, ~(^8'h5B), 1, -1, 0);
    check("R3 even parity error", pf, 1);
    check("R3 data with parity", rd_data, 9'h05B);
    consume();
    par_odd = 1;
    send(9'h033, 8, 1, ~(^8'h33), 1, -1, 0);
    check("R3 odd parity ok", pf, 0);
    consume();
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_framing();
    send(9'h03C, 8, 0, 0, 0, -1, 0);
    check("R4 framing flag", fe, 1);
    check("R4 data kept", rd_data, 9'h03C);
    consume();
    hold(3 * BIT_CLKS);
    check("R1 low stop gives no frame", rd_valid, 0);
    rx = 1'b0; hold(6); rx = 1'b1; hold(12 * BIT_CLKS);
    check("R1 short low pulse rejected", rd_valid, 0);
  endtask

  task automatic t_noise();
    send(9'h00F, 8, 0, 0, 1, 3, 0);
    check("R5 noise flag", nf, 1);
    check("R5 majority data", rd_data, 9'h00F);
    consume();
    check("R6 flags cleared by handshake", {nf, fe, pf, ovr}, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 0, 0, 1, -1, 0);
    send(9'h022, 8, 0, 0, 1, -1, 0);
    check("R7 overrun flag", ovr, 1);
    check("R7 first data kept", rd_data, 9'h011);
    consume();
    check("R7 overrun cleared", ovr, 0);
  endtask

  task automatic t_wake();
    wake = 1;
    rwu_set = 1; hold(1); rwu_set = 0; hold(1);
    check("R8 sleep entered", rwu, 1);
    send(9'h012, 8, 0, 0, 0, -1, 0);
    hold(2 * BIT_CLKS);
    check("R9 data frame ignored", rd_valid, 0);
    check("R9 no flags while asleep", {nf, fe, pf, ovr}, 0);
    check("R9 still asleep", rwu, 1);
    send(9'h085, 8, 0, 0, 1, -1, 1);
    check("R10 address frame delivered", rd_valid, 1);
    check("R10 address data", rd_data, 9'h085);
    check("R10 awake", rwu, 0);
    consume();
  endtask

  task automatic t_wake_off();
    wake = 0;
    rwu_set = 1; hold(1); rwu_set = 0; hold(1);
    check("R8 strobe ignored without wake mode", rwu, 0);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(4);
    t_reset();
    t_basic();
    t_nine();
    t_parity();
    t_framing();
    t_noise();
    t_overrun();
    t_wake();
    t_wake_off();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule